// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port with Pull-Up Control

This block is one parallel I/O port of a small microcontroller. Software reaches it over a simple register bus with an address, write and read strobes, write data and read data. The port holds two registers. One is a direction register that selects output or input for each pin. The other is a data latch that holds the value driven on output pins. The block drives three vectors toward the pads: output enable, output value and pull-up enable. It also samples the pad input levels.

Reading the data register returns the latch for output pins and the live pad level for input pins. The direction register is write-only, so software that reads it sees only ones. A pin gets its pull-up when it is an input and its latch bit is 1. Reset turns every pull-up off, and so does a hardware-standby request. The port width is a parameter from 6 to 8 bits. Bus bit positions above the width are not built.

Top module: `gpio_port`

## Requirements
- R1: A write to the direction register (address offset 1) sets pad_oe one clock later: a 1 in a bit makes that pin an output and a 0 makes it an input.
- R2: A write to the data register (address offset 0) updates the data latch whatever the direction, and pad_out shows the latch one clock later.
- R3: For pins whose direction bit is 1, a data-register read returns the latch bit, not the pad level.
- R4: For pins whose direction bit is 0, a data-register read returns the pad_in level sampled at the clock edge that takes the read strobe. No other input register lies in this path.
- R5: pad_pu for a pin is 1 exactly when its direction bit is 0 and its latch bit is 1. Writing 0 to the latch bit or 1 to the direction bit turns it off one clock after the write.
- R6: A read of the direction register address returns 8'hFF whatever is stored.
- R7: A synchronous reset clears the direction register, the data latch and bus_rdata to 0. pad_oe, pad_out and pad_pu read 0 after reset.
- R8: While hw_stby is high, pad_oe, pad_out and pad_pu are 0 from one clock after it rises, and register writes are ignored. After hw_stby falls both registers still hold their reset value of 0.
- R9: A data-register read returns 1 in every bit position at PORT_W or above. Write-data bits in those positions change nothing.
- R10: Reads of any address other than offsets 0 and 1 return 8'h00, and writes to such addresses change no register.
- R11: bus_rdata changes only on a clock edge that takes bus_rd high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_stby | input | 1 | Hardware standby request, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | PORT_W | Pad input levels |
| pad_oe | output | PORT_W | Pad output enables |
| pad_out | output | PORT_W | Pad output values |
| pad_pu | output | PORT_W | Pad pull-up enables |

## Verification
Each pad output is computed from the next register state, so it changes on the same clock edge that takes a write or a change of hw_stby. Read data is registered on the edge that takes bus_rd, and pad_in is sampled on that same edge. This gives every result a latency of one clock from the strobe. The bench drives all inputs just after a falling edge and checks at the next falling edge, so each check falls exactly one rising edge after its stimulus. The standby and unmapped-address checks read the pad outputs and read back the registers after the stimulus, before any further write, to show that nothing changed.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

  // Map a bus address onto one of the port registers.
  function automatic reg_sel_e decode_sel(input logic [31:0] addr,
                                          input logic [31:0] data_ofs,
                                          input logic [31:0] dir_ofs);
    if (addr == data_ofs)     return SEL_DATA;
    else if (addr == dir_ofs) return SEL_DIR;
    else                      return SEL_NONE;
  endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int PORT_W   = 7,
  parameter int ADDR_W   = 2,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] wr_bits,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] dat_q,
  output logic [PORT_W-1:0] dir_d,
  output logic [PORT_W-1:0] dat_d
);

  reg_sel_e sel;
  logic     wr_ok;
  logic     hold_clr;

  assign sel      = decode_sel(32'(bus_addr), 32'(DATA_OFS), 32'(DIR_OFS));
  assign wr_ok    = bus_wr & ~hw_stby;
  assign hold_clr = rst | hw_stby;

  // Next-state values, also handed to the pad stage so it sees writes early.
  always_comb begin
    dir_d = dir_q;
    dat_d = dat_q;
    if (hold_clr) begin
      dir_d = '0;
      dat_d = '0;
    end else if (wr_ok) begin
      if (sel == SEL_DIR)  dir_d = wr_bits;
      if (sel == SEL_DATA) dat_d = wr_bits;
    end
  end

  always_ff @(posedge clk) begin
    dir_q <= dir_d;
    dat_q <= dat_d;
  end

  // R8
  stby_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hw_stby) |-> (dir_q == '0 && dat_q == '0));

  // R2
  dat_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hw_stby && sel == SEL_DATA) |=> (dat_q == $past(wr_bits)));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hw_stby && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(dat_q)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int PORT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic [PORT_W-1:0] dir_d,
  input  logic [PORT_W-1:0] dat_d,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_pu
);

  logic kill;
  assign kill = rst | hw_stby;

  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    always_ff @(posedge clk) begin
      if (kill) begin
        pad_oe[b]  <= 1'b0;
        pad_out[b] <= 1'b0;
        pad_pu[b]  <= 1'b0;
      end else begin
        pad_oe[b]  <= dir_d[b];
        pad_out[b] <= dat_d[b];
        pad_pu[b]  <= ~dir_d[b] & dat_d[b];
      end
    end
  end

  // R8
  stby_pads_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hw_stby) |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int PORT_W   = 7,
  parameter int ADDR_W   = 2,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] dat_q,
  input  logic [PORT_W-1:0] pad_in,
  output logic [BUS_W-1:0]  bus_rdata
);

  reg_sel_e         sel;
  logic [BUS_W-1:0] data_view;
  logic [BUS_W-1:0] rd_next;

  assign sel = decode_sel(32'(bus_addr), 32'(DATA_OFS), 32'(DIR_OFS));

  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    if (b < PORT_W) begin : g_impl
      assign data_view[b] = dir_q[b] ? dat_q[b] : pad_in[b];
    end else begin : g_absent
      assign data_view[b] = 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_next = data_view;
      SEL_DIR:  rd_next = '1;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R6
  dir_reads_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_DIR) |=> (bus_rdata == '1));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PORT_W   = 7,
  parameter int ADDR_W   = 2,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_pu
);

  localparam int HI_W = BUS_W - PORT_W;

  logic [PORT_W-1:0] dir_q, dat_q, dir_d, dat_d;

  // Write-data bits above the port width are not implemented.
  if (HI_W > 0) begin : g_hi
    logic wdata_hi_unused;
    assign wdata_hi_unused = ^bus_wdata[BUS_W-1:PORT_W];
  end

  gpio_regfile #(
    .PORT_W(PORT_W), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .wr_bits(bus_wdata[PORT_W-1:0]),
    .dir_q(dir_q), .dat_q(dat_q), .dir_d(dir_d), .dat_d(dat_d)
  );

  gpio_pad_ctrl #(.PORT_W(PORT_W)) u_pads (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .dir_d(dir_d), .dat_d(dat_d),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  gpio_rdmux #(
    .PORT_W(PORT_W), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) u_rd (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .dir_q(dir_q), .dat_q(dat_q), .pad_in(pad_in), .bus_rdata(bus_rdata)
  );

  // R5
  pullup_match_chk: assert property (@(posedge clk) disable iff (rst)
    pad_pu == (~dir_q & dat_q));

  // R1
  oe_match_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe == dir_q);

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hw_stby = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [PW-1:0] pad_in = '0;
  logic [PW-1:0] pad_oe, pad_out, pad_pu;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R7 rdata after reset", bus_rdata, 8'h00);
    check("R7 pad_oe after reset", 8'(pad_oe), 8'h00);
    check("R7 pad_out after reset", 8'(pad_out), 8'h00);
    check("R7 pad_pu after reset", 8'(pad_pu), 8'h00);
    pad_in = 7'h55;
    bus_read(2'd0, v);
    check("R4 R9 all-input read", v, 8'hD5);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    bus_write(2'd1, 8'h0F);
    check("R1 pad_oe after dir write", 8'(pad_oe), 8'h0F);
    bus_read(2'd1, v);
    check("R6 dir reads ones", v, 8'hFF);
  endtask

  task automatic t_data();
    logic [7:0] v;
    bus_write(2'd0, 8'h3C);
    check("R2 pad_out follows latch", 8'(pad_out), 8'h3C);
    pad_in = 7'h41;
    bus_read(2'd0, v);
    check("R3 R4 mixed read", v, 8'hCC);
    pad_in = 7'h7F;
    bus_read(2'd0, v);
    check("R3 R4 live input read", v, 8'hFC);
  endtask

  task automatic t_pullup();
    check("R5 pull-up from input latch ones", 8'(pad_pu), 8'h30);
    bus_write(2'd0, 8'h2C);
    check("R5 latch 0 drops pull-up", 8'(pad_pu), 8'h20);
    bus_write(2'd1, 8'h2F);
    check("R5 output dir drops pull-up", 8'(pad_pu), 8'h00);
    bus_write(2'd1, 8'h0F);
    check("R5 back to input restores pull-up", 8'(pad_pu), 8'h20);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    bus_write(2'd0, 8'hFF);
    check("R9 upper write bit dropped", 8'(pad_out), 8'h7F);
    pad_in = 7'h00;
    bus_read(2'd0, v);
    check("R9 upper read bit is one", v, 8'h8F);
    bus_write(2'd1, 8'h80);
    check("R9 upper dir bit dropped", 8'(pad_oe), 8'h00);
    bus_write(2'd1, 8'h0F);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    bus_write(2'd2, 8'h00);
    check("R10 unmapped write keeps oe", 8'(pad_oe), 8'h0F);
    check("R10 unmapped write keeps latch", 8'(pad_out), 8'h7F);
    bus_read(2'd3, v);
    check("R10 unmapped read", v, 8'h00);
    bus_read(2'd1, v);
    repeat (3) @(negedge clk);
    check("R11 rdata holds without read", bus_rdata, 8'hFF);
  endtask

  task automatic t_standby();
    logic [7:0] v;
    bus_write(2'd0, 8'h70);
    check("R5 pull-ups before standby", 8'(pad_pu), 8'h70);
    hw_stby = 1'b1;
    @(negedge clk);
    check("R8 oe off in standby", 8'(pad_oe), 8'h00);
    check("R8 pull-up off in standby", 8'(pad_pu), 8'h00);
    check("R8 pad_out off in standby", 8'(pad_out), 8'h00);
    bus_write(2'd1, 8'h7F);
    bus_write(2'd0, 8'h7F);
    hw_stby = 1'b0;
    @(negedge clk);
    check("R8 dir write ignored in standby", 8'(pad_oe), 8'h00);
    check("R8 latch write ignored in standby", 8'(pad_out), 8'h00);
    pad_in = 7'h12;
    bus_read(2'd0, v);
    check("R8 regs at reset after standby", v, 8'h92);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direction();
    t_data();
    t_pullup();
    t_unused();
    t_unmapped();
    t_standby();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule